// File: doc/BRIEF.md
# A24 Memory Window Decoder with Slot Registers

This block holds the configuration and status registers for a carrier with up to four mezzanine slots, lettered A to D. It also turns each 24-bit standard-space memory address into a one-hot slot select and an offset relative to that slot. Software reaches the registers through a simple 8-bit bus. A write strobe with an address and data updates a register on the clock edge. Read data is driven combinationally from the current register address.

Each slot has three pieces of state:
- a memory enable bit;
- a 4-bit window base that lines up with address bits 23..20;
- a 2-bit window size code.

The size code picks 1, 2, 4 or 8 MB, which sets how many of the base bits take part in the match. A live error input per slot can be read back. The parameter `NUM_SLOTS` selects either the full four-slot build or a two-slot build in which slots C and D do not exist.

The decode result is registered. The select and the offset for an address presented in one cycle appear after the next rising clock edge. If software programs windows that overlap, the lowest-lettered matching slot wins, so the select never has more than one bit set.

Top module: `mem_win_decoder`

## Requirements
- R1: After reset all memory enables are 0 and every window register reads 0x00 (base 0, size code 00 = 1 MB), so no slot is selected.
- R2: A read at offset 0xC5 returns the live slot error inputs: bit 0 is slot A, bit 1 is B, bit 2 is C, bit 3 is D, and bits 7..4 read 0.
- R3: Offset 0xC7 holds the memory enables (bit 0 is slot A up to bit 3 is slot D). A written 1 enables a slot and a written 0 disables it. Bits 7..4 read 0.
- R4: Offsets 0xD1, 0xD3, 0xD5 and 0xD7 hold the window registers of slots A, B, C and D. Bits 7..4 hold the base and bits 1..0 hold the size code. Bits 3..2 always read 0 and writes to them are dropped.
- R5: The size code sets which address bits are compared with the base: 00 compares A23..A20, 01 compares A23..A21, 10 compares A23..A22, and 11 compares only A23.
- R6: All four base bits read back exactly as written, including the ones the current size code leaves out of the comparison.
- R7: A slot whose enable bit is 0 is never selected, whatever its window holds.
- R8: The offset is the address with the compared high bits forced to 0; for an 8 MB window it carries A22..A0. When no slot is selected the offset is 0.
- R9: When several enabled windows match, only the lowest-lettered one is selected, so the select is one-hot or all zero.
- R10: With `NUM_SLOTS` = 2, the slot C and D bits of the error and enable registers read 0, the C and D window registers read 0x00, and slots C and D are never selected.
- R11: Reads from unmapped offsets return 0x00. Writes to unmapped offsets and to the error register change no register.
- R12: The select and offset for an address show up on the outputs one clock edge after the address is presented, and they hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| slot_err | input | 4 | Live error input per slot, bit 0 is slot A |
| mem_addr | input | 24 | Standard-space memory address to decode |
| mem_sel | output | 4 | Registered one-hot slot select, bit 0 is slot A |
| mem_offset | output | 24 | Registered slot-relative offset |

## Verification
The bench builds two instances side by side. The first uses the default `NUM_SLOTS` = 4, which exposes all four windows: overlaps across every slot pair, the priority between them, and each size code. The second uses `NUM_SLOTS` = 2, which exposes the cut-down variant: the masked error and enable bits, the missing C and D registers, and an address sweep in which slots C and D must never be selected.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

    localparam int SLOT_MAX = 4;
    localparam int ADDR_W   = 24;
    localparam int DATA_W   = 8;
    localparam int BASE_W   = 4;
    localparam int LOW_W    = ADDR_W - BASE_W;
    localparam int SIZE_W   = 2;

    localparam logic [DATA_W-1:0] OFF_ERR   = 8'hC5;
    localparam logic [DATA_W-1:0] OFF_EN    = 8'hC7;
    localparam logic [DATA_W-1:0] OFF_WIN_A = 8'hD1;
    localparam int                WIN_STEP  = 2;

    typedef logic [SIZE_W-1:0] size_code_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        size_code_t        size;
    } win_cfg_t;

    typedef struct packed {
        logic [SLOT_MAX-1:0]            en;
        win_cfg_t [SLOT_MAX-1:0]        win;
    } reg_state_t;

    typedef struct packed {
        logic [SLOT_MAX-1:0] sel;
        logic [ADDR_W-1:0]   off;
    } dec_out_t;

    function automatic logic [DATA_W-1:0] win_offset(input int slot);
        return DATA_W'(int'(OFF_WIN_A) + WIN_STEP * slot);
    endfunction

    function automatic logic [BASE_W-1:0] cmp_mask(input size_code_t sz);
        return {BASE_W{1'b1}} << sz;
    endfunction

endpackage

// File: rtl/mwd_regs.sv
module mwd_regs
    import mwd_pkg::*;
#(
    parameter int NUM_SLOTS = SLOT_MAX
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [SLOT_MAX-1:0]      slot_err,
    output logic [DATA_W-1:0]        rdata,
    output logic [SLOT_MAX-1:0]      slot_en,
    output win_cfg_t [SLOT_MAX-1:0]  slot_cfg
);

    localparam logic [SLOT_MAX-1:0] SLOT_MASK = SLOT_MAX'((1 << NUM_SLOTS) - 1);
    localparam int                  PAD_W     = DATA_W - SLOT_MAX;
    localparam int                  GAP_W     = DATA_W - BASE_W - SIZE_W;

    reg_state_t          st_d, st_q;
    logic [DATA_W-1:0]   rdata_d;

    always_comb begin
        st_d    = st_q;
        rdata_d = '0;

        if (wr_en) begin
            if (addr == OFF_EN) begin
                st_d.en = wdata[SLOT_MAX-1:0] & SLOT_MASK;
            end
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (addr == win_offset(i)) begin
                    st_d.win[i].base = wdata[DATA_W-1 -: BASE_W];
                    st_d.win[i].size = wdata[SIZE_W-1:0];
                end
            end
        end

        case (addr)
            OFF_ERR: rdata_d = {{PAD_W{1'b0}}, slot_err & SLOT_MASK};
            OFF_EN:  rdata_d = {{PAD_W{1'b0}}, st_q.en};
            default: rdata_d = '0;
        endcase
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (addr == win_offset(i)) begin
                rdata_d = {st_q.win[i].base, {GAP_W{1'b0}}, st_q.win[i].size};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = rdata_d;
    assign slot_en  = st_q.en;
    assign slot_cfg = st_q.win;

endmodule

// File: rtl/mwd_window.sv
module mwd_window
    import mwd_pkg::*;
(
    input  logic              enable,
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);

    logic [BASE_W-1:0] mask;
    logic [BASE_W-1:0] hi;

    always_comb begin
        mask   = cmp_mask(cfg.size);
        hi     = addr[ADDR_W-1 -: BASE_W];
        hit    = enable && (((hi ^ cfg.base) & mask) == '0);
        offset = {hi & ~mask, addr[LOW_W-1:0]};
    end

endmodule

// File: rtl/mwd_select.sv
module mwd_select
    import mwd_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SLOT_MAX-1:0]            hit,
    input  logic [SLOT_MAX-1:0][ADDR_W-1:0] offs,
    output logic [SLOT_MAX-1:0]            sel,
    output logic [ADDR_W-1:0]              offset
);

    dec_out_t dec_d, dec_q;
    logic     found;

    always_comb begin
        dec_d = '0;
        found = 1'b0;
        for (int i = 0; i < SLOT_MAX; i++) begin
            if (hit[i] && !found) begin
                found        = 1'b1;
                dec_d.sel[i] = 1'b1;
                dec_d.off    = offs[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign sel    = dec_q.sel;
    assign offset = dec_q.off;

endmodule

// File: rtl/mem_win_decoder.sv
module mem_win_decoder
    import mwd_pkg::*;
#(
    parameter int NUM_SLOTS = SLOT_MAX
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [DATA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [SLOT_MAX-1:0] slot_err,
    input  logic [ADDR_W-1:0]   mem_addr,
    output logic [SLOT_MAX-1:0] mem_sel,
    output logic [ADDR_W-1:0]   mem_offset
);

    logic [SLOT_MAX-1:0]             slot_en;
    win_cfg_t [SLOT_MAX-1:0]         slot_cfg;
    logic [SLOT_MAX-1:0]             win_hit;
    logic [SLOT_MAX-1:0][ADDR_W-1:0] win_off;

    mwd_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .slot_err (slot_err),
        .rdata    (reg_rdata),
        .slot_en  (slot_en),
        .slot_cfg (slot_cfg)
    );

    for (genvar g = 0; g < SLOT_MAX; g++) begin : g_slot
        if (g < NUM_SLOTS) begin : g_live
            mwd_window u_win (
                .enable (slot_en[g]),
                .cfg    (slot_cfg[g]),
                .addr   (mem_addr),
                .hit    (win_hit[g]),
                .offset (win_off[g])
            );
        end else begin : g_absent
            assign win_hit[g] = 1'b0;
            assign win_off[g] = '0;
        end
    end

    mwd_select u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (win_hit),
        .offs   (win_off),
        .sel    (mem_sel),
        .offset (mem_offset)
    );

endmodule

// File: rtl/mwd_checker.sv
module mwd_checker
    import mwd_pkg::*;
#(
    parameter int NUM_SLOTS = SLOT_MAX
) (
    input logic                clk,
    input logic                rst_n,
    input logic [DATA_W-1:0]   reg_addr,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic [SLOT_MAX-1:0] slot_err,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [SLOT_MAX-1:0] mem_sel,
    input logic [ADDR_W-1:0]   mem_offset,
    input logic [SLOT_MAX-1:0] slot_en
);

    localparam logic [SLOT_MAX-1:0] SLOT_MASK = SLOT_MAX'((1 << NUM_SLOTS) - 1);

    p_err_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_ERR) |-> (reg_rdata == {4'b0000, slot_err & SLOT_MASK}));

    p_en_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_EN) |-> (reg_rdata[7:4] == 4'b0000));

    p_win_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'hD1 || reg_addr == 8'hD3 || reg_addr == 8'hD5 || reg_addr == 8'hD7)
        |-> (reg_rdata[3:2] == 2'b00));

    p_offset_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel == '0) |-> (mem_offset == '0));

    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_sel));

    p_low_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel != '0) |-> (mem_offset[LOW_W-1:0] == $past(mem_addr[LOW_W-1:0])));

    for (genvar g = 0; g < SLOT_MAX; g++) begin : g_chk
        p_enabled_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
            mem_sel[g] |-> $past(slot_en[g]));
        if (g >= NUM_SLOTS) begin : g_absent
            p_absent_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !mem_sel[g] && !slot_en[g]);
        end
    end

endmodule

bind mem_win_decoder mwd_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .slot_err   (slot_err),
    .mem_addr   (mem_addr),
    .mem_sel    (mem_sel),
    .mem_offset (mem_offset),
    .slot_en    (slot_en)
);

// File: tb/test_mem_win_decoder.sv
module test_mem_win_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  ra = 8'h00;
    logic [7:0]  wd = 8'h00;
    logic [7:0]  rd;
    logic [3:0]  err = 4'h0;
    logic [23:0] ma = 24'h0;
    logic [3:0]  sel;
    logic [23:0] off;

    logic        wr2 = 1'b0;
    logic [7:0]  ra2 = 8'h00;
    logic [7:0]  wd2 = 8'h00;
    logic [7:0]  rd2;
    logic [3:0]  err2 = 4'h0;
    logic [23:0] ma2 = 24'h0;
    logic [3:0]  sel2;
    logic [23:0] off2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] m_en;
    logic [3:0] m_base [4];
    logic [1:0] m_size [4];

    always #5 clk = ~clk;

    mem_win_decoder #(.NUM_SLOTS(4)) i_mem_win_decoder (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_addr(ra), .reg_wdata(wd),
        .reg_rdata(rd), .slot_err(err), .mem_addr(ma), .mem_sel(sel), .mem_offset(off)
    );

    mem_win_decoder #(.NUM_SLOTS(2)) i_mem_win_decoder_two (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr2), .reg_addr(ra2), .reg_wdata(wd2),
        .reg_rdata(rd2), .slot_err(err2), .mem_addr(ma2), .mem_sel(sel2), .mem_offset(off2)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        ra = a; wd = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        if (a == 8'hC7) m_en = d[3:0];
        for (int i = 0; i < 4; i++) begin
            if (a == 8'hD1 + 8'(2 * i)) begin
                m_base[i] = d[7:4];
                m_size[i] = d[1:0];
            end
        end
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        ra = a;
        #1 d = rd;
    endtask

    task automatic decode(input logic [23:0] a, output logic [3:0] s, output logic [23:0] o);
        @(negedge clk);
        ma = a;
        @(negedge clk);
        s = sel; o = off;
    endtask

    function automatic void model(input logic [23:0] a, output logic [3:0] s, output logic [23:0] o);
        logic [3:0] mk;
        s = 4'h0; o = 24'h0;
        for (int i = 0; i < 4; i++) begin
            mk = 4'hF << m_size[i];
            if (s == 4'h0 && m_en[i] && (((a[23:20] ^ m_base[i]) & mk) == 4'h0)) begin
                s = 4'(1 << i);
                o = {a[23:20] & ~mk, a[19:0]};
            end
        end
    endfunction

    task automatic dec_check(input string req, input logic [23:0] a);
        logic [3:0] s, es;
        logic [23:0] o, eo;
        decode(a, s, o);
        model(a, es, eo);
        check({req, " sel"}, 32'(s), 32'(es));
        check({req, " offset"}, 32'(o), 32'(eo));
    endtask

    task automatic t_reset_r1;
        logic [7:0] d;
        logic [3:0] s;
        logic [23:0] o;
        rd_reg(8'hC7, d); check("R1 enable reset", 32'(d), 32'h00);
        for (int i = 0; i < 4; i++) begin
            rd_reg(8'hD1 + 8'(2 * i), d); check("R1 window reset", 32'(d), 32'h00);
        end
        decode(24'h012345, s, o);
        check("R1 no select", 32'(s), 32'h0);
    endtask

    task automatic t_error_r2;
        logic [7:0] d;
        err = 4'b1010; rd_reg(8'hC5, d); check("R2 error A..D", 32'(d), 32'h0A);
        err = 4'b0101; rd_reg(8'hC5, d); check("R2 error live", 32'(d), 32'h05);
        err = 4'b0000; rd_reg(8'hC5, d); check("R2 error clear", 32'(d), 32'h00);
    endtask

    task automatic t_enable_r3;
        logic [7:0] d;
        wr_reg(8'hC7, 8'hFF); rd_reg(8'hC7, d); check("R3 enable upper zero", 32'(d), 32'h0F);
        wr_reg(8'hC7, 8'h06); rd_reg(8'hC7, d); check("R3 enable bits", 32'(d), 32'h06);
        wr_reg(8'hC7, 8'h00); rd_reg(8'hC7, d); check("R3 disable", 32'(d), 32'h00);
    endtask

    task automatic t_window_regs_r4_r6;
        logic [7:0] d;
        wr_reg(8'hD1, 8'hAF); rd_reg(8'hD1, d); check("R4 gap bits dropped", 32'(d), 32'hA3);
        wr_reg(8'hD3, 8'h72); rd_reg(8'hD3, d); check("R4 slot B window", 32'(d), 32'h72);
        wr_reg(8'hD7, 8'h5B); rd_reg(8'hD7, d); check("R4 slot D window", 32'(d), 32'h53);
        wr_reg(8'hD5, 8'hF7); rd_reg(8'hD5, d); check("R6 base kept at 8MB", 32'(d), 32'hF3);
        rd_reg(8'hD1, d); check("R6 slot A unchanged", 32'(d), 32'hA3);
    endtask

    task automatic t_sizes_r5_r8;
        logic [3:0] s;
        logic [23:0] o;
        wr_reg(8'hC7, 8'h01);
        for (int sz = 0; sz < 4; sz++) begin
            wr_reg(8'hD1, 8'h50 | 8'(sz));
            dec_check("R5 inside", 24'h5ABCDE);
            dec_check("R5 lower", 24'h456789);
            dec_check("R5 far", 24'hC00001);
            dec_check("R8 edge", 24'h7FFFFF);
        end
        wr_reg(8'hD1, 8'h53);
        decode(24'h456789, s, o);
        check("R8 8MB offset", 32'(o), 32'h456789);
        wr_reg(8'hD1, 8'h51);
        decode(24'h456789, s, o);
        check("R5 2MB select", 32'(s), 32'h1);
        check("R8 2MB offset", 32'(o), 32'h056789);
        decode(24'h356789, s, o);
        check("R8 idle offset", 32'(o), 32'h0);
    endtask

    task automatic t_disable_r7;
        logic [3:0] s;
        logic [23:0] o;
        wr_reg(8'hD3, 8'h30);
        wr_reg(8'hC7, 8'h00);
        decode(24'h312345, s, o);
        check("R7 disabled B", 32'(s), 32'h0);
        wr_reg(8'hC7, 8'h02);
        decode(24'h312345, s, o);
        check("R7 enabled B", 32'(s), 32'h2);
    endtask

    task automatic t_overlap_r9;
        logic [3:0] s;
        logic [23:0] o;
        wr_reg(8'hD1, 8'h80); wr_reg(8'hD3, 8'h80);
        wr_reg(8'hD5, 8'h83); wr_reg(8'hD7, 8'h82);
        wr_reg(8'hC7, 8'h0F);
        decode(24'h8ABCDE, s, o); check("R9 A wins", 32'(s), 32'h1);
        wr_reg(8'hC7, 8'h0E);
        decode(24'h8ABCDE, s, o); check("R9 B wins", 32'(s), 32'h2);
        wr_reg(8'hC7, 8'h0C);
        decode(24'h8ABCDE, s, o); check("R9 C wins", 32'(s), 32'h4);
        check("R9 C offset", 32'(o), 32'h0ABCDE);
        wr_reg(8'hC7, 8'h08);
        decode(24'h8ABCDE, s, o); check("R9 D only", 32'(s), 32'h8);
        wr_reg(8'hC7, 8'h0F);
        for (int k = 0; k < 16; k++) dec_check("R9 sweep", {4'(k), 20'h13579});
    endtask

    task automatic t_unmapped_r11;
        logic [7:0] d;
        wr_reg(8'hC7, 8'h05);
        wr_reg(8'hC5, 8'hFF);
        rd_reg(8'hC7, d); check("R11 error write ignored", 32'(d), 32'h05);
        err = 4'h0; rd_reg(8'hC5, d); check("R11 error reg read-only", 32'(d), 32'h00);
        @(negedge clk); ra = 8'hC6; wd = 8'hFF; wr = 1'b1;
        @(negedge clk); ra = 8'hD2; wd = 8'hFF;
        @(negedge clk); wr = 1'b0;
        rd_reg(8'hC7, d); check("R11 unmapped write enable", 32'(d), 32'h05);
        rd_reg(8'hD1, d); check("R11 unmapped write window", 32'(d), 32'h80);
        rd_reg(8'hD2, d); check("R11 unmapped read", 32'(d), 32'h00);
        rd_reg(8'h00, d); check("R11 unmapped read zero", 32'(d), 32'h00);
    endtask

    task automatic t_latency_r12;
        wr_reg(8'hC7, 8'h01);
        wr_reg(8'hD1, 8'h20);
        @(negedge clk); ma = 24'hF00000;
        @(negedge clk); check("R12 prior sel", 32'(sel), 32'h0);
        ma = 24'h2FEDCB;
        #1 check("R12 held before edge", 32'(sel), 32'h0);
        @(negedge clk);
        check("R12 after edge sel", 32'(sel), 32'h1);
        check("R12 after edge offset", 32'(off), 32'h0FEDCB);
    endtask

    task automatic t_two_slot_r10;
        logic [7:0] d;
        @(negedge clk); ra2 = 8'hC7; wd2 = 8'hFF; wr2 = 1'b1;
        @(negedge clk); ra2 = 8'hD5; wd2 = 8'h43;
        @(negedge clk); ra2 = 8'hD7; wd2 = 8'h43;
        @(negedge clk); ra2 = 8'hD1; wd2 = 8'hC0;
        @(negedge clk); ra2 = 8'hD3; wd2 = 8'hE0;
        @(negedge clk); wr2 = 1'b0; ra2 = 8'hC7;
        #1 check("R10 enable C/D zero", 32'(rd2), 32'h03);
        ra2 = 8'hD5; #1 check("R10 window C absent", 32'(rd2), 32'h00);
        ra2 = 8'hD7; #1 check("R10 window D absent", 32'(rd2), 32'h00);
        ra2 = 8'hD3; #1 check("R10 window B present", 32'(rd2), 32'hE0);
        err2 = 4'hF; ra2 = 8'hC5; #1 check("R10 error C/D zero", 32'(rd2), 32'h03);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); ma2 = {4'(k), 20'h00042};
            @(negedge clk);
            d = (k == 12) ? 8'h1 : ((k == 14) ? 8'h2 : 8'h0);
            check("R10 sweep select", 32'(sel2), 32'(d));
        end
    endtask

    initial begin
        m_en = 4'h0;
        for (int i = 0; i < 4; i++) begin m_base[i] = 4'h0; m_size[i] = 2'b00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r1;
        t_error_r2;
        t_enable_r3;
        t_window_regs_r4_r6;
        t_sizes_r5_r8;
        t_disable_r7;
        t_overlap_r9;
        t_unmapped_r11;
        t_latency_r12;
        t_two_slot_r10;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule